// File: doc/BRIEF.md
# Issue Window Wakeup-Select

This block is the waiting room between rename and execution in an out-of-order core. Decode writes one renamed instruction per cycle into a free slot. Each slot holds the instruction's source tags, a ready bit per source, its destination tag and an opaque payload. A slot keeps its entry until the entry is picked for issue, so the window can be much smaller than the reorder buffer. When no slot is free, the block raises a stall signal back to decode.

Every cycle, the writeback buses each present the tag of a produced result. Every waiting source that holds a matching tag becomes ready. This also applies to an instruction being written into the window in that same cycle. An age-ordered select stage then grants up to `ISSUE_W` entries whose sources are all ready, oldest first. Age is taken from allocation order. The granted entries leave the window, and their packets appear on registered issue outputs one cycle later. A flush empties the window and the issue registers in one cycle.

Top module: `issue_window`

## Requirements
- R1: After reset, `full_o` is 0 and every bit of `issue_valid_o` is 0.
- R2: An entry allocated with all sources marked ready is written at the clock edge where `alloc_valid_i` is sampled. Its payload and destination tag appear on issue slot 0 after the following edge, provided no older ready entry exists.
- R3: `full_o` is 1 exactly when all `DEPTH` slots hold entries. An allocation requested while `full_o` is 1 is dropped and never issues.
- R4: A broadcast on any writeback bus makes every waiting source with an equal tag ready at that edge. The entry then issues after the next edge once all of its sources are ready.
- R5: A broadcast whose tag matches none of an entry's sources leaves that entry waiting.
- R6: A broadcast in the same cycle as an allocation wakes the matching source of the entry being allocated.
- R7: Issue is oldest-first by allocation order, regardless of slot index. Slot 0 carries the oldest granted entry, slot 1 the next oldest, and a higher slot is never valid while a lower one is empty.
- R8: At most `ISSUE_W` entries issue per cycle, and each allocated entry issues exactly once.
- R9: `flush_i` empties every slot and clears `issue_valid_o` at the next edge. This includes a packet that would have been issued at that edge. Later broadcasts issue nothing from flushed entries.
- R10: An entry with two sources stays waiting until both are ready, and either writeback bus may supply either wakeup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the window and the issue registers |
| alloc_valid_i | input | 1 | Allocation request from decode |
| alloc_src_tag_i | input | NUM_SRC*TAG_W | Source tags of the new instruction |
| alloc_src_rdy_i | input | NUM_SRC | Source already produced at allocation |
| alloc_dst_tag_i | input | TAG_W | Destination tag of the new instruction |
| alloc_pay_i | input | PAY_W | Opaque operation payload |
| wb_valid_i | input | NUM_WB | Writeback bus valid flags |
| wb_tag_i | input | NUM_WB*TAG_W | Writeback broadcast tags |
| full_o | output | 1 | No free slot; decode must stall |
| issue_valid_o | output | ISSUE_W | Issue slot carries a packet |
| issue_dst_tag_o | output | ISSUE_W*TAG_W | Destination tag per issue slot |
| issue_pay_o | output | ISSUE_W*PAY_W | Payload per issue slot |

## Verification
Two latencies govern every result. An allocation or a broadcast takes effect at the edge that samples it. An issue packet resulting from that state appears one edge later, and `full_o` follows the slot state with no delay after the writing edge. The directed tasks drive inputs just after an edge and sample one time unit after each edge. Each task checks that nothing is issued right after the triggering edge and that the packet is present right after the next one. Ordering and drain checks then follow one issue group per cycle, comparing payloads against the allocation sequence the bench itself recorded.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned IQ_DEPTH   = 8;
  localparam int unsigned IQ_TAG_W   = 6;
  localparam int unsigned IQ_NUM_SRC = 2;
  localparam int unsigned IQ_NUM_WB  = 2;
  localparam int unsigned IQ_ISSUE_W = 2;
  localparam int unsigned IQ_PAY_W   = 8;
endpackage

// File: rtl/iq_entry.sv
module iq_entry #(
  parameter int unsigned TAG_W   = 6,
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned NUM_WB  = 2,
  parameter int unsigned PAY_W   = 8
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              flush_i,
  input  logic                              alloc_i,
  input  logic                              grant_i,
  input  logic [NUM_SRC-1:0][TAG_W-1:0]     src_tag_i,
  input  logic [NUM_SRC-1:0]                src_rdy_i,
  input  logic [TAG_W-1:0]                  dst_tag_i,
  input  logic [PAY_W-1:0]                  pay_i,
  input  logic [NUM_WB-1:0]                 wb_valid_i,
  input  logic [NUM_WB-1:0][TAG_W-1:0]      wb_tag_i,
  output logic                              valid_o,
  output logic                              ready_o,
  output logic [TAG_W-1:0]                  dst_tag_o,
  output logic [PAY_W-1:0]                  pay_o
);
  logic                          valid_q;
  logic [NUM_SRC-1:0][TAG_W-1:0] tag_q;
  logic [NUM_SRC-1:0]            rdy_q;
  logic [TAG_W-1:0]              dst_q;
  logic [PAY_W-1:0]              pay_q;
  logic [NUM_SRC-1:0]            hit_new, hit_old;

  // tag compare against every writeback bus, for incoming and stored tags
  always_comb begin
    for (int s = 0; s < NUM_SRC; s++) begin
      hit_new[s] = 1'b0;
      hit_old[s] = 1'b0;
      for (int b = 0; b < NUM_WB; b++) begin
        if (wb_valid_i[b] && wb_tag_i[b] == src_tag_i[s]) hit_new[s] = 1'b1;
        if (wb_valid_i[b] && wb_tag_i[b] == tag_q[s])     hit_old[s] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      tag_q   <= '0;
      rdy_q   <= '0;
      dst_q   <= '0;
      pay_q   <= '0;
    end else if (flush_i) begin
      valid_q <= 1'b0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      tag_q   <= src_tag_i;
      rdy_q   <= src_rdy_i | hit_new;
      dst_q   <= dst_tag_i;
      pay_q   <= pay_i;
    end else begin
      if (grant_i) valid_q <= 1'b0;
      rdy_q <= rdy_q | hit_old;
    end
  end

  assign valid_o   = valid_q;
  assign ready_o   = valid_q && (&rdy_q);
  assign dst_tag_o = dst_q;
  assign pay_o     = pay_q;

  p_ready_sticky_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o && !grant_i && !flush_i |=> ready_o);
  p_grant_ready_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_i |-> ready_o);
  p_alloc_free_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_i |-> !valid_q);
endmodule

// File: rtl/iq_age.sv
module iq_age #(
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic [DEPTH-1:0]             alloc_i,
  input  logic [DEPTH-1:0]             valid_i,
  output logic [DEPTH-1:0][DEPTH-1:0]  older_o
);
  // older_q[j][k]: entry j was allocated before entry k
  logic [DEPTH-1:0][DEPTH-1:0] older_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      older_q <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        if (alloc_i[k]) begin
          for (int j = 0; j < DEPTH; j++) begin
            older_q[k][j] <= 1'b0;
            older_q[j][k] <= valid_i[j];
          end
        end
      end
    end
  end

  assign older_o = older_q;

  for (genvar i = 0; i < DEPTH; i++) begin : g_row
    for (genvar j = i + 1; j < DEPTH; j++) begin : g_col
      p_age_total_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        valid_i[i] && valid_i[j] |-> older_q[i][j] != older_q[j][i]);
    end
  end
endmodule

// File: rtl/iq_select.sv
module iq_select #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned ISSUE_W = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [DEPTH-1:0]              req_i,
  input  logic [DEPTH-1:0][DEPTH-1:0]   older_i,
  output logic [ISSUE_W-1:0][DEPTH-1:0] grant_o,
  output logic [ISSUE_W-1:0]            gvalid_o
);
  logic [DEPTH-1:0] cand;

  // stage w takes the oldest request left over by stages below it
  always_comb begin
    cand = req_i;
    for (int w = 0; w < ISSUE_W; w++) begin
      grant_o[w] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        logic blk;
        blk = 1'b0;
        for (int j = 0; j < DEPTH; j++)
          if (cand[j] && older_i[j][i]) blk = 1'b1;
        if (cand[i] && !blk) grant_o[w][i] = 1'b1;
      end
      cand        = cand & ~grant_o[w];
      gvalid_o[w] = |grant_o[w];
    end
  end

  for (genvar w = 0; w < ISSUE_W; w++) begin : g_stage
    p_grant_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(grant_o[w]));
    p_grant_in_req_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (grant_o[w] & ~req_i) == '0);
    if (w > 0) begin : g_pack
      p_slot_packed_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        gvalid_o[w] |-> gvalid_o[w-1]);
      p_grant_disjoint_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (grant_o[w] & grant_o[w-1]) == '0);
    end
  end
endmodule

// File: rtl/issue_window.sv
module issue_window
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH   = IQ_DEPTH,
  parameter int unsigned TAG_W   = IQ_TAG_W,
  parameter int unsigned NUM_SRC = IQ_NUM_SRC,
  parameter int unsigned NUM_WB  = IQ_NUM_WB,
  parameter int unsigned ISSUE_W = IQ_ISSUE_W,
  parameter int unsigned PAY_W   = IQ_PAY_W
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              flush_i,
  input  logic                              alloc_valid_i,
  input  logic [NUM_SRC-1:0][TAG_W-1:0]     alloc_src_tag_i,
  input  logic [NUM_SRC-1:0]                alloc_src_rdy_i,
  input  logic [TAG_W-1:0]                  alloc_dst_tag_i,
  input  logic [PAY_W-1:0]                  alloc_pay_i,
  input  logic [NUM_WB-1:0]                 wb_valid_i,
  input  logic [NUM_WB-1:0][TAG_W-1:0]      wb_tag_i,
  output logic                              full_o,
  output logic [ISSUE_W-1:0]                issue_valid_o,
  output logic [ISSUE_W-1:0][TAG_W-1:0]     issue_dst_tag_o,
  output logic [ISSUE_W-1:0][PAY_W-1:0]     issue_pay_o
);
  logic [DEPTH-1:0]              ent_valid, ent_ready, grant_any, alloc_oh, alloc_vec;
  logic [DEPTH-1:0][TAG_W-1:0]   ent_dst;
  logic [DEPTH-1:0][PAY_W-1:0]   ent_pay;
  logic [DEPTH-1:0][DEPTH-1:0]   older;
  logic [ISSUE_W-1:0][DEPTH-1:0] grant;
  logic [ISSUE_W-1:0]            gvalid;
  logic [ISSUE_W-1:0][TAG_W-1:0] sel_dst;
  logic [ISSUE_W-1:0][PAY_W-1:0] sel_pay;
  logic                          found, alloc_fire;

  // lowest free slot
  always_comb begin
    alloc_oh = '0;
    found    = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!ent_valid[i] && !found) begin
        alloc_oh[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  assign full_o     = &ent_valid;
  assign alloc_fire = alloc_valid_i && !full_o && !flush_i;
  assign alloc_vec  = alloc_fire ? alloc_oh : '0;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    iq_entry #(
      .TAG_W(TAG_W), .NUM_SRC(NUM_SRC), .NUM_WB(NUM_WB), .PAY_W(PAY_W)
    ) u_entry (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .flush_i    (flush_i),
      .alloc_i    (alloc_vec[i]),
      .grant_i    (grant_any[i]),
      .src_tag_i  (alloc_src_tag_i),
      .src_rdy_i  (alloc_src_rdy_i),
      .dst_tag_i  (alloc_dst_tag_i),
      .pay_i      (alloc_pay_i),
      .wb_valid_i (wb_valid_i),
      .wb_tag_i   (wb_tag_i),
      .valid_o    (ent_valid[i]),
      .ready_o    (ent_ready[i]),
      .dst_tag_o  (ent_dst[i]),
      .pay_o      (ent_pay[i])
    );

    p_grant_frees_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      grant_any[i] |=> !ent_valid[i]);
  end

  iq_age #(.DEPTH(DEPTH)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (alloc_vec),
    .valid_i (ent_valid),
    .older_o (older)
  );

  iq_select #(.DEPTH(DEPTH), .ISSUE_W(ISSUE_W)) u_sel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (ent_ready),
    .older_i  (older),
    .grant_o  (grant),
    .gvalid_o (gvalid)
  );

  always_comb begin
    grant_any = '0;
    for (int w = 0; w < ISSUE_W; w++) begin
      grant_any  = grant_any | grant[w];
      sel_dst[w] = '0;
      sel_pay[w] = '0;
      for (int i = 0; i < DEPTH; i++) begin
        if (grant[w][i]) begin
          sel_dst[w] = sel_dst[w] | ent_dst[i];
          sel_pay[w] = sel_pay[w] | ent_pay[i];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_valid_o   <= '0;
      issue_dst_tag_o <= '0;
      issue_pay_o     <= '0;
    end else if (flush_i) begin
      issue_valid_o   <= '0;
    end else begin
      issue_valid_o   <= gvalid;
      issue_dst_tag_o <= sel_dst;
      issue_pay_o     <= sel_pay;
    end
  end

  p_flush_empty_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (ent_valid == '0) && (issue_valid_o == '0));
  p_full_holds_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && (grant_any == '0) && !flush_i |=> full_o);
  p_issue_from_grant_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> issue_valid_o == $past(gvalid));
endmodule

// File: tb/issue_window_bench.sv
module issue_window_bench;
  localparam int DEPTH = 8, TAG_W = 6, NUM_SRC = 2, NUM_WB = 2, ISSUE_W = 2, PAY_W = 8;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0, alloc_valid = 1'b0;
  logic [NUM_SRC-1:0][TAG_W-1:0] src_tag = '0;
  logic [NUM_SRC-1:0]            src_rdy = '0;
  logic [TAG_W-1:0]              dst_tag = '0;
  logic [PAY_W-1:0]              pay = '0;
  logic [NUM_WB-1:0]             wb_valid = '0;
  logic [NUM_WB-1:0][TAG_W-1:0]  wb_tag = '0;
  logic                          full;
  logic [ISSUE_W-1:0]            iss_valid;
  logic [ISSUE_W-1:0][TAG_W-1:0] iss_dst;
  logic [ISSUE_W-1:0][PAY_W-1:0] iss_pay;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  issue_window u_issue_window (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush), .alloc_valid_i(alloc_valid),
    .alloc_src_tag_i(src_tag), .alloc_src_rdy_i(src_rdy), .alloc_dst_tag_i(dst_tag),
    .alloc_pay_i(pay), .wb_valid_i(wb_valid), .wb_tag_i(wb_tag),
    .full_o(full), .issue_valid_o(iss_valid), .issue_dst_tag_o(iss_dst), .issue_pay_o(iss_pay)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic alloc(input int p, input int d, input int t0, input bit r0, input int t1, input bit r1);
    alloc_valid = 1'b1;
    pay = PAY_W'(p); dst_tag = TAG_W'(d);
    src_tag[0] = TAG_W'(t0); src_rdy[0] = r0;
    src_tag[1] = TAG_W'(t1); src_rdy[1] = r1;
    tick();
    alloc_valid = 1'b0;
  endtask

  task automatic bcast(input int b, input int t);
    wb_valid[b] = 1'b1;
    wb_tag[b]   = TAG_W'(t);
  endtask

  task automatic chk_none(input string req);
    chk(iss_valid == '0, req, iss_valid, 0);
  endtask

  task automatic t_reset();
    chk(full == 1'b0, "R1 full after reset", full, 0);
    chk_none("R1 issue after reset");
  endtask

  task automatic t_ready_alloc();
    alloc(8'h11, 3, 1, 1'b1, 2, 1'b1);
    chk_none("R2 not yet issued");
    tick();
    chk(iss_valid == 2'b01, "R2 issue slot valid", iss_valid, 1);
    chk(iss_pay[0] == 8'h11, "R2 payload", iss_pay[0], 8'h11);
    chk(iss_dst[0] == 6'd3, "R2 dst tag", iss_dst[0], 3);
    tick();
    chk_none("R8 issued once");
  endtask

  task automatic t_wakeup();
    alloc(8'h22, 4, 5, 1'b0, 6, 1'b0);
    tick();
    chk_none("R4 waiting entry");
    bcast(0, 7);
    tick();
    wb_valid = '0;
    tick();
    chk_none("R5 wrong tag no wake");
    bcast(1, 5);
    tick();
    wb_valid = '0;
    tick();
    chk_none("R10 one of two sources ready");
    bcast(0, 6);
    tick();
    wb_valid = '0;
    chk_none("R4 not issued at broadcast edge");
    tick();
    chk(iss_valid == 2'b01 && iss_pay[0] == 8'h22, "R4 R10 issue after wake", iss_pay[0], 8'h22);
    tick();
  endtask

  task automatic t_same_cycle();
    bcast(1, 9);
    alloc(8'h33, 5, 9, 1'b0, 1, 1'b1);
    wb_valid = '0;
    tick();
    chk(iss_valid == 2'b01 && iss_pay[0] == 8'h33, "R6 same-cycle wake", iss_pay[0], 8'h33);
    tick();
  endtask

  task automatic t_oldest();
    alloc(8'h50, 1, 20, 1'b0, 1, 1'b1);
    alloc(8'h51, 1, 12, 1'b0, 1, 1'b1);
    alloc(8'h52, 1, 12, 1'b0, 1, 1'b1);
    bcast(0, 20);
    tick();
    wb_valid = '0;
    tick();
    chk(iss_valid == 2'b01 && iss_pay[0] == 8'h50, "R7 first waiter", iss_pay[0], 8'h50);
    alloc(8'h53, 1, 12, 1'b0, 1, 1'b1);
    bcast(1, 12);
    tick();
    wb_valid = '0;
    tick();
    chk(iss_valid == 2'b11, "R8 two issued", iss_valid, 3);
    chk(iss_pay[0] == 8'h51, "R7 oldest in slot 0", iss_pay[0], 8'h51);
    chk(iss_pay[1] == 8'h52, "R7 second in slot 1", iss_pay[1], 8'h52);
    tick();
    chk(iss_valid == 2'b01 && iss_pay[0] == 8'h53, "R7 reused low slot issues last", iss_pay[0], 8'h53);
    tick();
    chk_none("R8 drained");
  endtask

  task automatic t_full();
    int cnt = 0;
    bit bad = 1'b0;
    for (int i = 0; i < DEPTH; i++) alloc(8'h40 + i, i, 30, 1'b0, 1, 1'b1);
    chk(full == 1'b1, "R3 full asserted", full, 1);
    alloc(8'h7F, 2, 1, 1'b1, 1, 1'b1);
    chk(full == 1'b1, "R3 full after dropped alloc", full, 1);
    tick();
    chk_none("R3 dropped alloc not issued");
    bcast(0, 30);
    tick();
    wb_valid = '0;
    for (int c = 0; c < DEPTH / ISSUE_W + 2; c++) begin
      tick();
      for (int w = 0; w < ISSUE_W; w++) begin
        if (iss_valid[w]) begin
          if (iss_pay[w] != PAY_W'(8'h40 + cnt)) bad = 1'b1;
          cnt++;
        end
      end
    end
    chk(cnt == DEPTH, "R3 R8 drain count", cnt, DEPTH);
    chk(!bad, "R7 drain in allocation order", bad, 0);
    chk(full == 1'b0, "R3 full clears", full, 0);
  endtask

  task automatic t_flush();
    for (int i = 0; i < DEPTH; i++) alloc(8'h60 + i, i, 41, 1'b0, 1, 1'b1);
    chk(full == 1'b1, "R9 window full before flush", full, 1);
    flush = 1'b1;
    tick();
    flush = 1'b0;
    chk(full == 1'b0, "R9 flush empties", full, 0);
    bcast(0, 41);
    tick();
    wb_valid = '0;
    tick();
    chk_none("R9 flushed entries stay gone");
    alloc(8'h70, 1, 1, 1'b1, 1, 1'b1);
    flush = 1'b1;
    tick();
    flush = 1'b0;
    chk_none("R9 pending issue killed");
    tick();
    chk_none("R9 nothing after flush");
    alloc(8'h71, 2, 1, 1'b1, 1, 1'b1);
    tick();
    chk(iss_valid == 2'b01 && iss_pay[0] == 8'h71, "R2 alloc after flush", iss_pay[0], 8'h71);
    tick();
  endtask

  initial begin
    #400000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_ready_alloc();
    t_wakeup();
    t_same_cycle();
    t_oldest();
    t_full();
    t_flush();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule